// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style) in front of a small byte-wide register array. A master opens each transaction with a START condition and sends an address byte. Bits 7:1 of that byte carry the 7-bit device identity and bit 0 selects the direction. For a write, the master sends two word-address bytes, most significant first, then one data byte. A STOP condition then commits the byte, but only when the STOP falls exactly on a byte boundary. For a read, the slave returns bytes starting at an internal address counter. That counter advances after every data byte. A random read is an address-only write followed by a repeated START and a read address byte.

Writes to the array are gated by a write-enable latch. Software arms the latch by writing a key value to a dedicated control address. Each committed array write starts a modelled nonvolatile programming cycle with a fixed length in system clocks. While that cycle runs, the slave does not acknowledge its own address, so the master can poll until it gets an ACK. SCL and SDA are brought into the system clock domain through synchronisers. The system clock must run at least eight times faster than SCL. The slave drives SDA low only through an open-drain enable.

Top module: `smem_slave`

## Requirements
- R1: After reset, sda_oe is 0, the write-enable latch is clear and every array byte is 0x00. The first current-address read returns 0x00.
- R2: The address byte carries the device identity in bits 7:1 and the direction in bit 0, where 1 means read. With a different identity the byte is not acknowledged, and the slave ignores all bus traffic until the next START.
- R3: A write transaction carries, in order, the address byte with bit 0 at 0, the upper word-address byte, the lower word-address byte and one data byte. It is followed by STOP with no bit clocked after the data byte's ACK. Such a write, with the latch set, stores the byte at array index = the low log2(DEPTH) bits of the word address.
- R4: A write of 0x5A to word address 0x8000 sets the write-enable latch, and any other value written there clears it. A control write never changes the array and never starts a busy cycle. With the latch clear, array writes are still acknowledged but change nothing and start no busy cycle.
- R5: A random read returns the byte at the word address just loaded. It consists of an address-only write, a repeated START and a read address byte.
- R6: The address counter advances by one after each data byte that is transferred. A current-address read, which has no word-address phase, returns the byte at the counter. The index wraps modulo DEPTH.
- R7: During a read, a master ACK after a byte makes the slave send the next sequential byte. A master NACK ends the read and the slave releases SDA.
- R8: After a committed array write, the slave does not acknowledge its address byte for BUSY_CYCLES system clocks, and acknowledges it again afterwards.
- R9: A STOP that arrives after part of a byte has been clocked commits nothing. A second data byte in one write is not acknowledged, and the whole write is dropped.
- R10: sda_oe changes only while SCL is low. It is asserted only in slave ACK bit cells and in read data bit cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |

## Verification
The bench tracks where the STOP lands relative to the byte count. A STOP with no bit clocked after the data byte's ACK must commit, and a STOP after a few clocked bits must not. A design that miscounts the clock edge of the STOP itself would either lose every write or accept torn ones. Polling right after a commit must see one NACK and then an ACK, and polling after a blocked or control write must see an immediate ACK. A design that started the busy timer on every STOP would fail that check. Reads chain across a random read, a current-address read, a sequential burst and a wrap from the last index to index 0. These catch an off-by-one counter or a missing increment after the last byte sent. On every clock the bench compares sda_oe against the bit cells where the slave may drive, and flags any change while SCL is high.

// File: rtl/smem_pkg.sv
package smem_pkg;

  // bus-level engine state
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed; wait for START
    ST_RX,     // shifting in a byte from the master
    ST_RXEND,  // byte taken, waiting for SCL low to drive ACK
    ST_ACK,    // driving ACK bit cell
    ST_TX,     // shifting out a data byte
    ST_TXEND,  // last data bit on the wire, release at next SCL low
    ST_MACK,   // master acknowledge bit cell
    ST_MNEXT   // master asked for more, load at next SCL low
  } bus_st_t;

  // which byte of the transaction is being received
  typedef enum logic [1:0] {
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } phase_t;

  function automatic logic [15:0] addr_step(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  function automatic phase_t phase_after(input phase_t ph);
    case (ph)
      PH_DEV:  return PH_AHI;
      PH_AHI:  return PH_ALO;
      default: return PH_DATA;
    endcase
  endfunction

  // ACK decision for a completed received byte
  function automatic logic take_byte(input phase_t ph, input logic [7:0] b,
                                     input logic [6:0] id, input logic busy,
                                     input logic full);
    case (ph)
      PH_DEV:  return (b[7:1] == id) && !busy;
      PH_DATA: return !full;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smem_busy_timer.sv
module smem_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !start) |=> (cnt == $past(cnt) - 1'b1)); // R8

endmodule

// File: rtl/smem_regfile.sv
module smem_regfile #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/smem_slave.sv
module smem_slave #(
  parameter logic [6:0]  DEV_ID      = 7'h52,
  parameter int          DEPTH       = 64,
  parameter logic [15:0] CTRL_ADDR   = 16'h8000,
  parameter logic [7:0]  WEL_KEY     = 8'h5A,
  parameter int          BUSY_CYCLES = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  import smem_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  // synchronised line events
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  // engine state
  bus_st_t     st;
  phase_t      phase;
  logic [2:0]  bitcnt;
  logic [7:0]  shreg;
  logic        rw;
  logic [7:0]  addr_hi;
  logic [15:0] addr_ctr;
  logic [7:0]  wbuf;
  logic [15:0] wbuf_addr;
  logic        have_data;
  logic        wel;
  logic [7:0]  txbuf;

  // named internal events
  logic [7:0] rx_byte;
  logic       byte_in;
  logic       acc;
  logic       commit;
  logic       ctrl_we;
  logic       mem_we;
  logic       tx_load;
  logic       busy;
  logic [7:0] rdata;

  assign rx_byte = {shreg[6:0], sda_s};
  assign byte_in = (st == ST_RX) && scl_rise && (bitcnt == 3'd7);
  assign acc     = take_byte(phase, rx_byte, DEV_ID, busy, have_data);

  // a STOP is on a byte boundary when at most its own SCL high has been clocked
  assign commit  = bus_stop && (st == ST_RX) && (phase == PH_DATA) && have_data
                   && (bitcnt <= 3'd1);
  assign ctrl_we = commit && (wbuf_addr == CTRL_ADDR);
  assign mem_we  = commit && (wbuf_addr != CTRL_ADDR) && wel;

  assign tx_load = scl_fall && (((st == ST_ACK) && (phase == PH_DEV) && rw)
                                || (st == ST_MNEXT));

  smem_regfile #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (wbuf_addr[IDX_W-1:0]),
    .wdata (wbuf),
    .raddr (addr_ctr[IDX_W-1:0]),
    .rdata (rdata)
  );

  smem_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mem_we),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= PH_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      addr_hi   <= '0;
      addr_ctr  <= '1;
      wbuf      <= '0;
      wbuf_addr <= '0;
      have_data <= 1'b0;
      wel       <= 1'b0;
      txbuf     <= '0;
      sda_oe    <= 1'b0;
    end else if (bus_start) begin
      st        <= ST_RX;
      phase     <= PH_DEV;
      bitcnt    <= '0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (bus_stop) begin
      st        <= ST_IDLE;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
      if (ctrl_we) wel <= (wbuf == WEL_KEY);
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              st     <= acc ? ST_RXEND : ST_IDLE;
              if (acc) begin
                case (phase)
                  PH_DEV: rw      <= rx_byte[0];
                  PH_AHI: addr_hi <= rx_byte;
                  PH_ALO: addr_ctr <= {addr_hi, rx_byte};
                  default: begin
                    wbuf      <= rx_byte;
                    wbuf_addr <= addr_ctr;
                    addr_ctr  <= addr_step(addr_ctr);
                    have_data <= 1'b1;
                  end
                endcase
              end else begin
                have_data <= 1'b0;
              end
            end
          end
        end
        ST_RXEND: begin
          if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if ((phase == PH_DEV) && rw) begin
              txbuf    <= rdata;
              sda_oe   <= ~rdata[7];
              addr_ctr <= addr_step(addr_ctr);
              st       <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= phase_after(phase);
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) st <= ST_TXEND;
          end
          if (scl_fall) begin
            txbuf  <= {txbuf[6:0], 1'b0};
            sda_oe <= ~txbuf[6];
          end
        end
        ST_TXEND: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_MACK;
          end
        end
        ST_MACK: begin
          if (scl_rise) st <= sda_s ? ST_IDLE : ST_MNEXT;
        end
        ST_MNEXT: begin
          if (scl_fall) begin
            txbuf    <= rdata;
            sda_oe   <= ~rdata[7];
            addr_ctr <= addr_step(addr_ctr);
            bitcnt   <= '0;
            st       <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sda_oe != $past(sda_oe)) |-> (!scl_s || $past(bus_start || bus_stop))); // R10
  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ((st == ST_ACK) && (phase == PH_DEV)) |-> !busy); // R8
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> busy); // R8
  AST_COMMIT_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !busy); // R8
  AST_WEL_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> $past(ctrl_we)); // R4
  AST_TX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) tx_load |=> (addr_ctr == addr_step($past(addr_ctr)))); // R6
  AST_BYTE_DROP: assert property (@(posedge clk) disable iff (!rst_n) (byte_in && !acc) |=> (st == ST_IDLE) && !sda_oe); // R2

endmodule

// File: tb/smem_slave_test.sv
module smem_slave_test;

  localparam logic [6:0]  DEV   = 7'h52;
  localparam int          DEPTH = 64;
  localparam logic [15:0] CTRL  = 16'h8000;
  localparam logic [7:0]  KEY   = 8'h5A;
  localparam int          BUSY  = 600;
  localparam int          HP    = 16;
  localparam int          Q     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_oe ? 1'b0 : msda;

  always #4 clk = ~clk;

  smem_slave #(.DEV_ID(DEV), .DEPTH(DEPTH), .CTRL_ADDR(CTRL), .WEL_KEY(KEY),
               .BUSY_CYCLES(BUSY)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl),
    .sda_in (sda_line),
    .sda_oe (sda_oe)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic win = 1'b0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  // reference model state
  logic [7:0]  exp_mem [DEPTH];
  logic [15:0] exp_ctr;
  logic        exp_wel;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison of the open-drain enable with the allowed cells (R10)
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(!(sda_oe && !win), "R10 drive outside slave cell", sda_oe, 0);
      chk(!((sda_oe != prev_oe) && scl), "R10 change while SCL high", sda_oe, prev_oe);
      prev_oe = sda_oe;
    end
  end

  task automatic bus_start();
    msda = 1'b1; clks(HP);
    scl = 1'b1;  clks(HP);
    msda = 1'b0; clks(HP);
    scl = 1'b0;  clks(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; clks(HP);
    scl = 1'b1;  clks(HP);
    msda = 1'b1; clks(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      msda = b[i]; clks(HP);
      scl = 1'b1;  clks(HP);
      scl = 1'b0;  clks(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit keep, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; clks(HP);
      scl = 1'b1;  clks(HP);
      scl = 1'b0;
      if (i == 0) win = 1'b1;
      clks(Q);
    end
    msda = 1'b1; clks(HP);
    scl = 1'b1;  clks(HP / 2);
    ack = (sda_line == 1'b0);
    clks(HP / 2);
    scl = 1'b0;  clks(Q);
    win = keep;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      clks(HP);
      scl = 1'b1; clks(HP / 2);
      b[i] = sda_line;
      clks(HP / 2);
      scl = 1'b0; clks(Q);
    end
    win = 1'b0;
    msda = mack ? 1'b0 : 1'b1; clks(HP);
    scl = 1'b1; clks(HP);
    scl = 1'b0;
    win = mack;
    clks(Q);
    msda = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    bit k0, k1, k2, k3;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, k0);
    send_byte(a[15:8], 1'b0, k1);
    send_byte(a[7:0], 1'b0, k2);
    send_byte(d, 1'b0, k3);
    bus_stop();
    chk(k0 && k1 && k2 && k3, req, {k0, k1, k2, k3}, 4'hF);
    exp_ctr = a + 16'd1;
    if (a == CTRL) exp_wel = (d == KEY);
    else if (exp_wel) exp_mem[int'(a) % DEPTH] = d;
  endtask

  task automatic poll(input bit exp_busy, input string req);
    bit k;
    int nacks;
    k = 1'b0;
    nacks = 0;
    for (int t = 0; t < 30; t++) begin
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, k);
      bus_stop();
      if (k) break;
      nacks++;
    end
    chk(k, req, k, 1);
    if (exp_busy) chk(nacks >= 1, req, nacks, 1);
    else          chk(nacks == 0, req, nacks, 0);
  endtask

  task automatic rd_rand(input logic [15:0] a, input int n, input string req);
    bit k0, k1, k2, k3;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, k0);
    send_byte(a[15:8], 1'b0, k1);
    send_byte(a[7:0], 1'b0, k2);
    bus_start();
    send_byte({DEV, 1'b1}, 1'b1, k3);
    chk(k0 && k1 && k2 && k3, req, {k0, k1, k2, k3}, 4'hF);
    exp_ctr = a;
    for (int j = 0; j < n; j++) begin
      recv_byte(j < n - 1, b);
      chk(b == exp_mem[int'(exp_ctr) % DEPTH], req, b, exp_mem[int'(exp_ctr) % DEPTH]);
      exp_ctr = exp_ctr + 16'd1;
    end
    bus_stop();
  endtask

  task automatic rd_cur(input string req);
    bit k;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b1}, 1'b1, k);
    chk(k, req, k, 1);
    recv_byte(1'b0, b);
    chk(b == exp_mem[int'(exp_ctr) % DEPTH], req, b, exp_mem[int'(exp_ctr) % DEPTH]);
    exp_ctr = exp_ctr + 16'd1;
    bus_stop();
  endtask

  initial begin
    bit k0, k1, k2, k3, k4;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
    exp_ctr = 16'hFFFF;
    exp_wel = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    rd_cur("R1 first current read");

    // R4: latch clear blocks array writes, no busy cycle
    wr(16'h0005, 8'h33, "R4 blocked write acks");
    poll(1'b0, "R4 no busy after blocked write");
    rd_rand(16'h0005, 1, "R4 blocked write left array");

    // R4: arm latch, control write starts no busy
    wr(CTRL, KEY, "R4 key write");
    poll(1'b0, "R4 no busy after control write");

    // R3 / R8 / R5: committed writes, polling, random read
    wr(16'h0005, 8'h3C, "R3 write 5");
    poll(1'b1, "R8 busy after write 5");
    rd_rand(16'h0005, 1, "R5 random read 5");
    wr(16'h0006, 8'hA7, "R3 write 6");
    poll(1'b1, "R8 busy after write 6");
    wr(16'h0007, 8'h19, "R3 write 7");
    poll(1'b1, "R8 busy after write 7");

    // R6: current-address reads follow the counter
    rd_cur("R6 current read after write");
    rd_rand(16'h0005, 1, "R6 random read 5");
    rd_cur("R6 current read n+1");
    rd_cur("R6 current read n+2");

    // R7: sequential burst then NACK
    rd_rand(16'h0005, 3, "R7 sequential read");
    rd_cur("R7 counter after burst");

    // R6: index wrap across the top of the array
    wr(16'h003F, 8'hE1, "R3 write 63");
    poll(1'b1, "R8 busy after write 63");
    wr(16'h0000, 8'h4B, "R3 write 0");
    poll(1'b1, "R8 busy after write 0");
    rd_rand(16'h003F, 2, "R6 wrap read");

    // R2: foreign identity, then bytes without START
    bus_start();
    send_byte({7'h30, 1'b0}, 1'b0, k0);
    chk(!k0, "R2 foreign write address", k0, 0);
    send_byte({DEV, 1'b0}, 1'b0, k1);
    chk(!k1, "R2 ignored until START", k1, 0);
    bus_stop();
    bus_start();
    send_byte({7'h30, 1'b1}, 1'b0, k0);
    chk(!k0, "R2 foreign read address", k0, 0);
    bus_stop();

    // R9: STOP in the middle of the first data byte
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, k0);
    send_byte(8'h00, 1'b0, k1);
    send_byte(8'h09, 1'b0, k2);
    send_bits(8'h77, 3);
    bus_stop();
    chk(k0 && k1 && k2, "R9 partial byte acks", {k0, k1, k2}, 3'h7);
    poll(1'b0, "R9 no busy after torn byte");
    rd_rand(16'h0009, 1, "R9 torn byte not stored");

    // R9: full data byte, then torn second byte
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, k0);
    send_byte(8'h00, 1'b0, k1);
    send_byte(8'h0A, 1'b0, k2);
    send_byte(8'h77, 1'b0, k3);
    send_bits(8'h55, 3);
    bus_stop();
    chk(k0 && k1 && k2 && k3, "R9 acks before tear", {k0, k1, k2, k3}, 4'hF);
    poll(1'b0, "R9 no busy after late tear");
    rd_rand(16'h000A, 1, "R9 late tear not stored");

    // R9: second data byte refused, write dropped
    bus_start();
    send_byte({DEV, 1'b0}, 1'b0, k0);
    send_byte(8'h00, 1'b0, k1);
    send_byte(8'h0B, 1'b0, k2);
    send_byte(8'h11, 1'b0, k3);
    send_byte(8'h22, 1'b0, k4);
    bus_stop();
    chk(k0 && k1 && k2 && k3, "R9 first data byte acked", {k0, k1, k2, k3}, 4'hF);
    chk(!k4, "R9 second data byte refused", k4, 0);
    poll(1'b0, "R9 no busy after dropped write");
    rd_rand(16'h000B, 1, "R9 dropped write not stored");

    // R4: non-key value clears the latch
    wr(CTRL, 8'h00, "R4 clear latch");
    poll(1'b0, "R4 no busy after clear");
    wr(16'h000C, 8'h55, "R4 write after clear acks");
    poll(1'b0, "R4 no busy when latch clear");
    rd_rand(16'h000C, 1, "R4 write after clear blocked");
    rd_rand(16'h0005, 1, "R4 earlier data intact");

    clks(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule